// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a serial audio stream made of a bit clock, a frame clock and one data line, and turns it into parallel samples. It runs as a slave. All three serial lines are oversampled by a faster system clock through a synchronizer. The frame clock and the data bit are taken on each rising edge of the bit clock.

Configuration inputs select the framing. Two stereo framings place the word at the start of each half-frame: one with a one-bit delay after the frame-clock transition and one without. A third stereo framing places the word at the end of the half-frame. A time-division framing carries 8 or 16 slots of 32 bit clocks each, with slot 0 marked by a frame-clock pulse. The word length is 16, 20 or 24 bits in every framing. Data arrives MSB first in two's complement.

Each finished word is mapped into a signed 28-bit value in 5.23 format. The block presents it together with a channel index and a one-cycle valid strobe.

Top module: `sai_rx`

## Requirements
- R1: While reset is asserted and right after it, smp_valid_o is 0, smp_chan_o is 0 and smp_data_o is 0.
- R2: With fmt_i = 0 (delayed stereo), the MSB is the bit taken on the second rising bit-clock edge after a frame-clock transition. Channel 0 is the half where the frame clock is low, and channel 1 the half where it is high.
- R3: With fmt_i = 1 (start-aligned stereo), the MSB is the bit taken on the first rising bit-clock edge at which the new frame-clock level is seen. Channel 0 is the half where the frame clock is high.
- R4: With fmt_i = 2 (end-aligned stereo), the LSB is the last bit before the next frame-clock transition, and the sample is delivered at that transition. Channel 0 is the half where the frame clock is high. Bits earlier than the word length in the half are discarded.
- R5: With fmt_i = 3 (time-division), a rising frame clock marks slot 0, and that bit is the slot's MSB. Each slot is 32 bit clocks long. Channels run 0..7 when tdm16_i = 0 and 0..15 when tdm16_i = 1. Slots after the last one are not delivered until the next pulse.
- R6: wsel_i codes the word length: 0 for 16 bits, 1 for 20 bits, 2 for 24 bits. Bits of a slot outside the word have no effect on the delivered sample.
- R7: The delivered word is left-aligned with its MSB at bit 23. Bits 27..24 repeat bit 23, and the bits below the word are 0.
- R8: Every completed channel raises smp_valid_o for exactly one system-clock cycle, with smp_chan_o holding that channel's index.
- R9: No sample is delivered before the first frame-clock transition that follows reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| lrclk_i | input | 1 | Frame clock (stereo half select or slot-0 pulse) |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | Framing: 0 delayed stereo, 1 start-aligned, 2 end-aligned, 3 time-division |
| wsel_i | input | 2 | Word length: 0 = 16, 1 = 20, 2 = 24 bits |
| tdm16_i | input | 1 | Time-division slot count: 0 = 8, 1 = 16 |
| smp_valid_o | output | 1 | One-cycle strobe per completed channel |
| smp_chan_o | output | 4 | Channel index of the delivered sample |
| smp_data_o | output | 28 | Sample in signed 5.23 format |

## Verification
The case that is hardest to reach from the ports is the end-aligned framing. There, every sample is delivered only at the next frame-clock transition and must ignore all of the earlier bits of its half. The stimulus fills every bit outside the word with ones, adds a lead-in half that only primes frame alignment, and closes with a single-bit trailer half whose transition flushes the last word. Both word-length extremes are covered, along with the most negative and most positive codes.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;
    localparam int WORD_MAX  = 24;
    localparam int SAMPLE_W  = 28;
    localparam int SLOT_BITS = 32;
    localparam int CNT_W     = $clog2(SLOT_BITS);
    localparam int CHAN_W    = 4;

    typedef enum logic [1:0] {
        FMT_DLY  = 2'd0,
        FMT_LEFT = 2'd1,
        FMT_RGT  = 2'd2,
        FMT_TDM  = 2'd3
    } fmt_e;

    typedef struct packed {
        logic                primed;
        logic                active;
        logic                lr_prev;
        logic [CNT_W-1:0]    cnt;
        logic [CHAN_W-1:0]   slot;
        logic [WORD_MAX-1:0] shreg;
        logic                valid;
        logic [CHAN_W-1:0]   chan;
        logic [SAMPLE_W-1:0] data;
    } rx_state_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/rx_wordmap.sv
module rx_wordmap
    import sai_rx_pkg::*;
(
    input  logic [WORD_MAX-1:0] raw,
    input  logic [1:0]          wsel,
    output logic [SAMPLE_W-1:0] smp
);
    localparam int EXT = SAMPLE_W - WORD_MAX;

    logic [WORD_MAX-1:0] aligned;

    always_comb begin
        case (wsel)
            2'd0:    aligned = {raw[15:0], 8'b0};
            2'd1:    aligned = {raw[19:0], 4'b0};
            default: aligned = raw;
        endcase
        smp = {{EXT{aligned[WORD_MAX-1]}}, aligned};
    end
endmodule

// File: rtl/sai_rx.sv
module sai_rx
    import sai_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                lrclk_i,
    input  logic                sdata_i,
    input  logic [1:0]          fmt_i,
    input  logic [1:0]          wsel_i,
    input  logic                tdm16_i,
    output logic                smp_valid_o,
    output logic [CHAN_W-1:0]   smp_chan_o,
    output logic [SAMPLE_W-1:0] smp_data_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_BITS - 1);

    logic [2:0] pins_s;
    logic       bclk_s, lr_s, dat_s;
    logic       bclk_prev_q;
    logic       rise;

    rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bclk_i, lrclk_i, sdata_i}),
        .dout (pins_s)
    );
    assign {bclk_s, lr_s, dat_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_prev_q <= 1'b0;
        else        bclk_prev_q <= bclk_s;
    end
    assign rise = bclk_s & ~bclk_prev_q;

    rx_state_t           st_q, st_d;
    logic [WORD_MAX-1:0] raw_sel;
    logic [SAMPLE_W-1:0] mapped;

    rx_wordmap u_map (
        .raw (raw_sel),
        .wsel(wsel_i),
        .smp (mapped)
    );

    fmt_e                fmt;
    logic [CNT_W-1:0]    wl_m1;
    logic [CNT_W-1:0]    tgt;
    logic [CHAN_W-1:0]   last_slot;
    logic [WORD_MAX-1:0] sh_next;
    logic                is_edge;
    logic                emit;
    logic [CHAN_W-1:0]   emit_chan;

    always_comb begin
        fmt = fmt_e'(fmt_i);
        case (wsel_i)
            2'd0:    wl_m1 = CNT_W'(15);
            2'd1:    wl_m1 = CNT_W'(19);
            default: wl_m1 = CNT_W'(23);
        endcase
        tgt       = wl_m1 + {{(CNT_W-1){1'b0}}, (fmt == FMT_DLY)};
        last_slot = tdm16_i ? CHAN_W'(15) : CHAN_W'(7);
        sh_next   = {st_q.shreg[WORD_MAX-2:0], dat_s};
        is_edge   = st_q.primed &&
                    ((fmt == FMT_TDM) ? (lr_s && !st_q.lr_prev) : (lr_s != st_q.lr_prev));

        st_d      = st_q;
        st_d.valid = 1'b0;
        emit      = 1'b0;
        emit_chan = st_q.slot;
        raw_sel   = st_q.shreg;

        if (rise) begin
            st_d.shreg   = sh_next;
            st_d.lr_prev = lr_s;
            st_d.primed  = 1'b1;
            if (is_edge) begin
                if (fmt == FMT_RGT && st_q.active) begin
                    emit      = 1'b1;
                    emit_chan = st_q.slot;
                    raw_sel   = st_q.shreg;
                end
                st_d.active = 1'b1;
                st_d.cnt    = '0;
                if (fmt == FMT_TDM)      st_d.slot = '0;
                else if (fmt == FMT_DLY) st_d.slot = lr_s ? CHAN_W'(1) : CHAN_W'(0);
                else                     st_d.slot = lr_s ? CHAN_W'(0) : CHAN_W'(1);
            end else if (st_q.active) begin
                if (fmt == FMT_TDM && st_q.cnt == CNT_LAST) begin
                    st_d.cnt = '0;
                    if (st_q.slot == last_slot) st_d.active = 1'b0;
                    else                        st_d.slot   = st_q.slot + 1'b1;
                end else if (st_q.cnt != CNT_LAST) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            if (fmt != FMT_RGT && st_d.active && st_d.cnt == tgt) begin
                emit      = 1'b1;
                emit_chan = st_d.slot;
                raw_sel   = sh_next;
            end
        end

        if (emit) begin
            st_d.valid = 1'b1;
            st_d.chan  = emit_chan;
            st_d.data  = mapped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_valid_o = st_q.valid;
    assign smp_chan_o  = st_q.chan;
    assign smp_data_o  = st_q.data;

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |=> !smp_valid_o);

    // R7
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> (smp_data_o[SAMPLE_W-1:WORD_MAX-1] == '0 ||
                         smp_data_o[SAMPLE_W-1:WORD_MAX-1] == '1));

    // R6
    low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && wsel_i == 2'd0) |-> (smp_data_o[7:0] == 8'd0));

    // R5
    tdm_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && fmt_i == 2'd3 && !tdm16_i) |-> (smp_chan_o < CHAN_W'(8)));

    // R2
    stereo_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_o && fmt_i != 2'd3) |-> (smp_chan_o < CHAN_W'(2)));

    // R8
    valid_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> $past(rise));
endmodule

// File: tb/tb_sai_rx.sv
module tb_sai_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_i = 1'b0, lrclk_i = 1'b0, sdata_i = 1'b0;
    logic [1:0]  fmt_i = 2'd0, wsel_i = 2'd0;
    logic        tdm16_i = 1'b0;
    logic        smp_valid_o;
    logic [3:0]  smp_chan_o;
    logic [27:0] smp_data_o;

    int checks = 0;
    int errors = 0;

    logic [27:0] exp_d [64];
    logic [3:0]  exp_c [64];
    int          exp_n;
    logic [27:0] got_d [64];
    logic [3:0]  got_c [64];
    int          got_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    sai_rx dut (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
        .sdata_i(sdata_i), .fmt_i(fmt_i), .wsel_i(wsel_i), .tdm16_i(tdm16_i),
        .smp_valid_o(smp_valid_o), .smp_chan_o(smp_chan_o), .smp_data_o(smp_data_o)
    );

    always @(negedge clk) begin
        if (rst_n && smp_valid_o) begin
            if (got_n < 64) begin
                got_d[got_n] = smp_data_o;
                got_c[got_n] = smp_chan_o;
            end
            got_n++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] mkword(int k, int wl);
        logic [31:0] m;
        m = (32'd1 << wl) - 1;
        if (k == 0)      return 24'((32'd1 << (wl-1)) & m);
        else if (k == 1) return 24'(((32'd1 << (wl-1)) - 1) & m);
        else             return 24'(((k * 32'h005A3C71) ^ 32'h00A5F0C3) & m);
    endfunction

    function automatic logic [27:0] expect_of(logic [23:0] w, int wl);
        longint s;
        s = longint'(w);
        if (w[wl-1]) s = s - (longint'(1) << wl);
        s = s * (longint'(1) << (24 - wl));
        return 28'(s);
    endfunction

    task automatic send_bit(input logic lr, input logic d);
        @(negedge clk);
        lrclk_i = lr; sdata_i = d; bclk_i = 1'b0;
        repeat (HALF_BIT) @(negedge clk);
        bclk_i = 1'b1;
        repeat (HALF_BIT - 1) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] f, input logic [1:0] ws, input logic t16);
        rst_n = 1'b0; bclk_i = 1'b0; lrclk_i = 1'b0; sdata_i = 1'b0;
        fmt_i = f; wsel_i = ws; tdm16_i = t16;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        got_n = 0; exp_n = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic compare(input string tag);
        repeat (20) @(negedge clk);
        check(got_n == exp_n, {tag, " R8 count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_d[i] == exp_d[i], {tag, " R7 data"}, got_d[i], exp_d[i]);
            check(got_c[i] == exp_c[i], {tag, " R8 chan"}, got_c[i], exp_c[i]);
        end
    endtask

    task automatic run_stereo(input logic [1:0] f, input int wsi, input string tag);
        int wl;
        logic lv0;
        wl = 16 + 4 * wsi;
        do_reset(f, 2'(wsi), 1'b0);
        lv0 = (f == 2'd0) ? 1'b0 : 1'b1;
        // R9: lead-in half primes alignment and must produce nothing
        for (int i = 0; i < 4; i++) send_bit(~lv0, 1'b1);
        for (int fr = 0; fr < 2; fr++) begin
            for (int h = 0; h < 2; h++) begin
                logic [23:0] w;
                logic lv;
                logic b;
                w  = mkword(fr * 2 + h, wl);
                lv = h[0] ? ~lv0 : lv0;
                exp_d[exp_n] = expect_of(w, wl);
                exp_c[exp_n] = 4'(h);
                exp_n++;
                for (int i = 0; i < 32; i++) begin
                    if (f == 2'd0)      b = (i >= 1 && i <= wl) ? w[wl - i] : 1'b1;
                    else if (f == 2'd1) b = (i < wl) ? w[wl - 1 - i] : 1'b1;
                    else                b = (i >= 32 - wl) ? w[31 - i] : 1'b1;
                    send_bit(lv, b);
                end
            end
        end
        send_bit(lv0, 1'b0);
        compare(tag);
    endtask

    task automatic run_tdm(input int wsi, input logic t16, input string tag);
        int wl;
        int ns;
        wl = 16 + 4 * wsi;
        ns = t16 ? 16 : 8;
        do_reset(2'd3, 2'(wsi), t16);
        for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b1);
        for (int fr = 0; fr < 2; fr++) begin
            for (int s = 0; s < ns; s++) begin
                logic [23:0] w;
                w = mkword(fr * ns + s, wl);
                exp_d[exp_n] = expect_of(w, wl);
                exp_c[exp_n] = 4'(s);
                exp_n++;
                for (int i = 0; i < 32; i++)
                    send_bit((s == 0 && i == 0), (i < wl) ? w[wl - 1 - i] : 1'b1);
            end
        end
        // R5: bits past the last slot are not delivered
        for (int i = 0; i < 40; i++) send_bit(1'b0, 1'b1);
        compare(tag);
    endtask

    initial begin
        got_n = 0; exp_n = 0;
        repeat (3) @(negedge clk);
        // R1
        check(smp_valid_o == 1'b0, "R1 valid in reset", smp_valid_o, 0);
        check(smp_data_o == 28'd0, "R1 data in reset", smp_data_o, 0);
        check(smp_chan_o == 4'd0, "R1 chan in reset", smp_chan_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(smp_valid_o == 1'b0, "R1 valid after reset", smp_valid_o, 0);

        for (int ws = 0; ws < 3; ws++) begin
            run_stereo(2'd0, ws, "R2 R6 delayed");
            run_stereo(2'd1, ws, "R3 R6 start");
            run_stereo(2'd2, ws, "R4 R6 end");
        end
        for (int ws = 0; ws < 3; ws++) begin
            run_tdm(ws, 1'b0, "R5 R6 tdm8");
            run_tdm(ws, 1'b1, "R5 R6 tdm16");
        end

        // R9: frame clock held without a transition gives no samples
        do_reset(2'd1, 2'd0, 1'b0);
        for (int i = 0; i < 40; i++) send_bit(1'b1, 1'b1);
        compare("R9 no transition");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule